// File: doc/BRIEF.md
# I/O Address Window Decoder

This block decides, for each I/O cycle address presented to it, whether the cycle belongs to the low-pin-count peripheral bus. It watches a 16-bit I/O address that arrives with a valid strobe. One clock later it reports a forward/hit flag and a vector with one bit per decode window that matched.

Two kinds of window are supported. Seven fixed legacy windows each have their own enable bit: two configuration-port pairs, two embedded-controller port pairs, two gameport halves, and a parallel-port window whose address range is picked by a 2-bit select. A parameterized number of generic windows (four by default) each carry a base address, a don't-care mask on address bits 7:2 and an enable. Generic windows match on 4-byte (dword) granularity and can cover up to 256 bytes.

A simple indexed write/read port programs all the decode registers. Reserved bits are dropped on write and read back as zero.

Top module: `io_window_decoder`

## Requirements
- R1: After reset every decode register reads 0 at every index, and a strobed address produces fwd_hit=0 and fwd_src=0.
- R2: Register index 0 is the enable register and keeps only bits 13..8 and 2. Index 1 is the parallel-port select and keeps bits 1:0. Indices 2..5 are generic windows 0..3 and keep only bits 23:18 (mask), 15:2 (base) and 0 (enable). Indices 6 and 7 read 0 and ignore writes. All other bits read 0.
- R3: Enable bit 12 forwards exactly 0x2E and 0x2F, reported on fwd_src[0]. Enable bit 13 forwards exactly 0x4E and 0x4F, reported on fwd_src[1].
- R4: Enable bit 10 forwards only 0x60 and 0x64, reported on fwd_src[2]. Enable bit 11 forwards only 0x62 and 0x66, reported on fwd_src[3]. Addresses between these (for example 0x61, 0x63, 0x65) do not match.
- R5: Enable bit 8 forwards 0x200..0x207 on fwd_src[4]. Enable bit 9 forwards 0x208..0x20F on fwd_src[5]. An address with any bit above bit 11 set never hits a fixed window.
- R6: Enable bit 2 forwards the parallel-port window on fwd_src[6]. Select 00 gives 0x378..0x37F and 0x778..0x77F. Select 10 gives 0x3BC..0x3BE and 0x7BC..0x7BE. Selects 01 and 11 match nothing.
- R7: Generic window k, reported on fwd_src[7+k], hits when its enable is set, address bits 15:8 equal base bits 15:8, and each address bit 7:2 whose mask bit is 0 equals the base bit. Address bits 1:0 are never compared.
- R8: A mask bit of 1 makes the corresponding address bit 7:2 a don't-care, whatever the base bit holds. All six mask bits set give a 256-byte window.
- R9: The generic windows are independent. A window whose enable bit 0 is clear (including an all-zero register) never hits.
- R10: fwd_hit and fwd_src are registered: they reflect the address strobed on the previous clock edge. A clock edge with io_valid low gives fwd_hit=0 and fwd_src=0. A configuration write takes effect for addresses strobed on later edges.
- R11: When several windows match one address, every matching fwd_src bit is set and fwd_hit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | IDX_W (3) | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the register at cfg_idx (combinational) |
| io_valid | input | 1 | I/O address strobe |
| io_addr | input | ADDR_W (16) | I/O cycle address |
| fwd_hit | output | 1 | Address is forwarded (registered) |
| fwd_src | output | 7+NGEN (11) | One bit per matching window (registered) |

## Verification
A corrupted enable, select or window register shows up in one of two places: at cfg_rdata during the same cycle it is addressed, or at the fwd_src bit of the affected window on the first clock edge after a strobed address that probes it. The stimulus therefore sweeps the edge addresses just inside and just outside each window. This catches an off-by-one bound or a wrong bit within a single cycle. Overlapping windows, a swapped parallel-port select and disabled generic windows are each probed, so that a crossed source bit or a missing gate appears as a wrong bit in fwd_src rather than only as a wrong fwd_hit.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

   // fixed window source positions in the match vector
   localparam int FIX_N       = 7;
   localparam int SRC_SIO     = 0;
   localparam int SRC_MC2     = 1;
   localparam int SRC_KBC     = 2;
   localparam int SRC_MC1     = 3;
   localparam int SRC_GAME_LO = 4;
   localparam int SRC_GAME_HI = 5;
   localparam int SRC_LPT     = 6;

   // enable register bit positions
   localparam int EN_LPT_BIT     = 2;
   localparam int EN_GAME_LO_BIT = 8;
   localparam int EN_GAME_HI_BIT = 9;
   localparam int EN_KBC_BIT     = 10;
   localparam int EN_MC1_BIT     = 11;
   localparam int EN_SIO_BIT     = 12;
   localparam int EN_MC2_BIT     = 13;

   // implemented bits per register kind
   localparam logic [31:0] EN_KEEP  = 32'h0000_3F04;
   localparam logic [31:0] SEL_KEEP = 32'h0000_0003;
   localparam logic [31:0] GEN_KEEP = 32'h00FC_FFFD;

   // generic window field layout
   localparam int GEN_MASK_LO = 18;
   localparam int GEN_MASK_W  = 6;
   localparam int GEN_BASE_LO = 2;
   localparam int GEN_BASE_W  = 14;
   localparam int GEN_SPAN_W  = GEN_BASE_W + GEN_BASE_LO;

   typedef enum logic [1:0] {
      LPT_PRIMARY = 2'b00,
      LPT_RSVD_A  = 2'b01,
      LPT_MONO    = 2'b10,
      LPT_RSVD_B  = 2'b11
   } lpt_sel_e;

   typedef struct packed {
      logic mc2;
      logic sio;
      logic mc1;
      logic kbc;
      logic game_hi;
      logic game_lo;
      logic lpt;
   } fix_en_t;

   typedef struct packed {
      logic [GEN_MASK_W-1:0] dc_mask;
      logic [GEN_BASE_W-1:0] base;
      logic                  on;
   } gen_win_t;

endpackage

// File: rtl/iodec_regs.sv
module iodec_regs
   import iodec_pkg::*;
#(
   parameter int NGEN  = 4,
   parameter int IDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [IDX_W-1:0]     cfg_idx,
   input  logic [31:0]          cfg_wdata,
   output logic [31:0]          cfg_rdata,
   output fix_en_t              fix_en,
   output lpt_sel_e             lpt_sel,
   output gen_win_t [NGEN-1:0]  gen_win
);

   localparam int IDX_EN   = 0;
   localparam int IDX_SEL  = 1;
   localparam int IDX_GEN0 = 2;

   logic unused_wbits;
   assign unused_wbits = ^{cfg_wdata[31:24], cfg_wdata[17:16]};

   logic wr_en, wr_sel;
   assign wr_en  = cfg_we && (cfg_idx == IDX_W'(IDX_EN));
   assign wr_sel = cfg_we && (cfg_idx == IDX_W'(IDX_SEL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fix_en  <= '0;
         lpt_sel <= LPT_PRIMARY;
      end else begin
         if (wr_en) begin
            fix_en.mc2     <= cfg_wdata[EN_MC2_BIT];
            fix_en.sio     <= cfg_wdata[EN_SIO_BIT];
            fix_en.mc1     <= cfg_wdata[EN_MC1_BIT];
            fix_en.kbc     <= cfg_wdata[EN_KBC_BIT];
            fix_en.game_hi <= cfg_wdata[EN_GAME_HI_BIT];
            fix_en.game_lo <= cfg_wdata[EN_GAME_LO_BIT];
            fix_en.lpt     <= cfg_wdata[EN_LPT_BIT];
         end
         if (wr_sel) begin
            lpt_sel <= lpt_sel_e'(cfg_wdata[1:0]);
         end
      end
   end

   for (genvar k = 0; k < NGEN; k++) begin : g_win
      logic wr_k;
      assign wr_k = cfg_we && (cfg_idx == IDX_W'(IDX_GEN0 + k));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gen_win[k] <= '0;
         end else if (wr_k) begin
            gen_win[k].dc_mask <= cfg_wdata[GEN_MASK_LO +: GEN_MASK_W];
            gen_win[k].base    <= cfg_wdata[GEN_BASE_LO +: GEN_BASE_W];
            gen_win[k].on      <= cfg_wdata[0];
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_idx == IDX_W'(IDX_EN)) begin
         cfg_rdata[EN_MC2_BIT]     = fix_en.mc2;
         cfg_rdata[EN_SIO_BIT]     = fix_en.sio;
         cfg_rdata[EN_MC1_BIT]     = fix_en.mc1;
         cfg_rdata[EN_KBC_BIT]     = fix_en.kbc;
         cfg_rdata[EN_GAME_HI_BIT] = fix_en.game_hi;
         cfg_rdata[EN_GAME_LO_BIT] = fix_en.game_lo;
         cfg_rdata[EN_LPT_BIT]     = fix_en.lpt;
      end else if (cfg_idx == IDX_W'(IDX_SEL)) begin
         cfg_rdata[1:0] = lpt_sel;
      end
      for (int k = 0; k < NGEN; k++) begin
         if (cfg_idx == IDX_W'(IDX_GEN0 + k)) begin
            cfg_rdata[GEN_MASK_LO +: GEN_MASK_W] = gen_win[k].dc_mask;
            cfg_rdata[GEN_BASE_LO +: GEN_BASE_W] = gen_win[k].base;
            cfg_rdata[0]                         = gen_win[k].on;
         end
      end
   end

   AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg_idx) >= IDX_GEN0 && int'(cfg_idx) < IDX_GEN0 + NGEN)
         |-> ((cfg_rdata & ~GEN_KEEP) == 32'h0)); // R2

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(fix_en) && $stable(lpt_sel) && $stable(gen_win))); // R2

endmodule

// File: rtl/iodec_fixed.sv
module iodec_fixed
   import iodec_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  fix_en_t             fix_en,
   input  lpt_sel_e            lpt_sel,
   input  logic [ADDR_W-1:0]   addr,
   output logic [FIX_N-1:0]    hit
);

   function automatic logic is_at(input logic [ADDR_W-1:0] a, input int v);
      return a == ADDR_W'(v);
   endfunction

   function automatic logic in_span(input logic [ADDR_W-1:0] a, input int lo, input int hi);
      return (a >= ADDR_W'(lo)) && (a <= ADDR_W'(hi));
   endfunction

   logic lpt_primary_hit, lpt_mono_hit, lpt_win;

   always_comb begin
      lpt_primary_hit = in_span(addr, 'h378, 'h37F) || in_span(addr, 'h778, 'h77F);
      lpt_mono_hit    = in_span(addr, 'h3BC, 'h3BE) || in_span(addr, 'h7BC, 'h7BE);
      unique case (lpt_sel)
         LPT_PRIMARY: lpt_win = lpt_primary_hit;
         LPT_MONO:    lpt_win = lpt_mono_hit;
         default:     lpt_win = 1'b0;
      endcase
   end

   always_comb begin
      hit              = '0;
      hit[SRC_SIO]     = fix_en.sio && (is_at(addr, 'h2E) || is_at(addr, 'h2F));
      hit[SRC_MC2]     = fix_en.mc2 && (is_at(addr, 'h4E) || is_at(addr, 'h4F));
      hit[SRC_KBC]     = fix_en.kbc && (is_at(addr, 'h60) || is_at(addr, 'h64));
      hit[SRC_MC1]     = fix_en.mc1 && (is_at(addr, 'h62) || is_at(addr, 'h66));
      hit[SRC_GAME_LO] = fix_en.game_lo && in_span(addr, 'h200, 'h207);
      hit[SRC_GAME_HI] = fix_en.game_hi && in_span(addr, 'h208, 'h20F);
      hit[SRC_LPT]     = fix_en.lpt && lpt_win;
   end

endmodule

// File: rtl/iodec_gen_win.sv
module iodec_gen_win
   import iodec_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  gen_win_t            win,
   input  logic [ADDR_W-1:0]   addr,
   output logic                hit
);

   logic [GEN_SPAN_W-1:0] care;
   logic [GEN_SPAN_W-1:0] ref_addr;
   logic                  upper_clear;
   logic                  low_match;

   always_comb begin
      care = '1;
      care[GEN_BASE_LO-1:0] = '0;
      care[GEN_BASE_LO +: GEN_MASK_W] = ~win.dc_mask;
      ref_addr = {win.base, {GEN_BASE_LO{1'b0}}};
   end

   if (ADDR_W > GEN_SPAN_W) begin : g_upper
      assign upper_clear = (addr[ADDR_W-1:GEN_SPAN_W] == '0);
   end else begin : g_no_upper
      assign upper_clear = 1'b1;
   end

   assign low_match = (((addr[GEN_SPAN_W-1:0] ^ ref_addr) & care) == '0);
   assign hit       = win.on && upper_clear && low_match;

endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
   import iodec_pkg::*;
#(
   parameter  int NGEN   = 4,
   parameter  int ADDR_W = 16,
   localparam int IDX_W  = $clog2(NGEN + 2),
   localparam int SRC_N  = FIX_N + NGEN
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_rdata,
   input  logic               io_valid,
   input  logic [ADDR_W-1:0]  io_addr,
   output logic               fwd_hit,
   output logic [SRC_N-1:0]   fwd_src
);

   if (NGEN < 1 || NGEN > 8) begin : g_bad_ngen
      $error("io_window_decoder: NGEN must be within 1..8");
   end
   if (ADDR_W < GEN_SPAN_W) begin : g_bad_addr
      $error("io_window_decoder: ADDR_W must cover the 16-bit I/O space");
   end

   fix_en_t              fix_en;
   lpt_sel_e             lpt_sel;
   gen_win_t [NGEN-1:0]  gen_win;
   logic [FIX_N-1:0]     fix_hit;
   logic [NGEN-1:0]      gen_hit;
   logic [SRC_N-1:0]     match;

   iodec_regs #(.NGEN(NGEN), .IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .fix_en    (fix_en),
      .lpt_sel   (lpt_sel),
      .gen_win   (gen_win)
   );

   iodec_fixed #(.ADDR_W(ADDR_W)) u_fixed (
      .fix_en  (fix_en),
      .lpt_sel (lpt_sel),
      .addr    (io_addr),
      .hit     (fix_hit)
   );

   for (genvar k = 0; k < NGEN; k++) begin : g_gen
      iodec_gen_win #(.ADDR_W(ADDR_W)) u_win (
         .win  (gen_win[k]),
         .addr (io_addr),
         .hit  (gen_hit[k])
      );

      AST_GEN_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         (io_valid && !gen_win[k].on) |=> !fwd_src[FIX_N + k]); // R9
   end

   assign match = {gen_hit, fix_hit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_hit <= 1'b0;
         fwd_src <= '0;
      end else begin
         fwd_hit <= io_valid && (match != '0);
         fwd_src <= io_valid ? match : '0;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !io_valid |=> (!fwd_hit && fwd_src == '0)); // R10

   AST_LPT_SEL_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (io_valid && lpt_sel[0]) |=> !fwd_src[SRC_LPT]); // R6

   AST_HIGH_ADDR_FIXED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (io_valid && io_addr[ADDR_W-1:12] != '0) |=> (fwd_src[FIX_N-1:0] == '0)); // R5

   AST_SRC_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_src != '0) |-> fwd_hit); // R11

endmodule

// File: tb/tb_io_window_decoder.sv
module tb_io_window_decoder;

   localparam int CLK_PERIOD = 10;
   localparam int NGEN = 4;
   localparam int IDX_W = 3;
   localparam int SRC_N = 11;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_we = 1'b0;
   logic [IDX_W-1:0]   cfg_idx = '0;
   logic [31:0]        cfg_wdata = '0;
   logic [31:0]        cfg_rdata;
   logic               io_valid = 1'b0;
   logic [15:0]        io_addr = '0;
   logic               fwd_hit;
   logic [SRC_N-1:0]   fwd_src;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   io_window_decoder dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_valid(io_valid),
      .io_addr(io_addr), .fwd_hit(fwd_hit), .fwd_src(fwd_src)
   );

   // shadow of programmed registers, masked per R2
   logic [31:0] sh_en = 0, sh_sel = 0;
   logic [31:0] sh_gen [NGEN];

   typedef struct {
      logic [SRC_N-1:0] src;
      logic [15:0]      addr;
      string            tag;
   } exp_t;
   exp_t sb [$];
   exp_t cur;

   function automatic bit span(logic [15:0] a, int lo, int hi);
      return (int'(a) >= lo) && (int'(a) <= hi);
   endfunction

   function automatic logic [SRC_N-1:0] model(logic [15:0] a);
      logic [SRC_N-1:0] s = '0;
      logic [15:0] care, base;
      s[0] = sh_en[12] && (a == 16'h2E || a == 16'h2F);
      s[1] = sh_en[13] && (a == 16'h4E || a == 16'h4F);
      s[2] = sh_en[10] && (a == 16'h60 || a == 16'h64);
      s[3] = sh_en[11] && (a == 16'h62 || a == 16'h66);
      s[4] = sh_en[8] && span(a, 'h200, 'h207);
      s[5] = sh_en[9] && span(a, 'h208, 'h20F);
      s[6] = sh_en[2] &&
             ((sh_sel[1:0] == 2'b00 && (span(a, 'h378, 'h37F) || span(a, 'h778, 'h77F))) ||
              (sh_sel[1:0] == 2'b10 && (span(a, 'h3BC, 'h3BE) || span(a, 'h7BC, 'h7BE))));
      for (int k = 0; k < NGEN; k++) begin
         care = 16'hFFFC & ~{8'h00, sh_gen[k][23:18], 2'b00};
         base = sh_gen[k][15:0] & 16'hFFFC;
         s[7+k] = sh_gen[k][0] && (((a ^ base) & care) == 16'h0);
      end
      return s;
   endfunction

   // monitor: pops one expected item per clock once results are due
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         cur = sb.pop_front();
         checks++;
         if (fwd_src !== cur.src || fwd_hit !== (cur.src != '0)) begin
            errors++;
            $display("FAIL %s addr=%h src=%b hit=%b expected src=%b hit=%b",
                     cur.tag, cur.addr, fwd_src, fwd_hit, cur.src, (cur.src != '0));
         end
      end
   end

   task automatic decode(input logic [15:0] a, input string tag);
      @(negedge clk);
      cfg_we = 1'b0;
      io_valid = 1'b1;
      io_addr = a;
      @(posedge clk);
      sb.push_back('{src: model(a), addr: a, tag: tag});
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      cfg_we = 1'b0;
      io_valid = 1'b0;
      io_addr = 16'h002E;
      @(posedge clk);
      sb.push_back('{src: '0, addr: 16'h002E, tag: tag});
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      @(negedge clk);
      io_valid = 1'b0;
      cfg_we = 1'b1;
      cfg_idx = IDX_W'(idx);
      cfg_wdata = d;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      if (idx == 0) sh_en = d & 32'h0000_3F04;
      else if (idx == 1) sh_sel = d & 32'h3;
      else if (idx >= 2 && idx < 2 + NGEN) sh_gen[idx-2] = d & 32'h00FC_FFFD;
   endtask

   task automatic rd_check(input int idx, input logic [31:0] exp, input string tag);
      @(negedge clk);
      io_valid = 1'b0;
      cfg_idx = IDX_W'(idx);
      #1;
      checks++;
      if (cfg_rdata !== exp) begin
         errors++;
         $display("FAIL %s idx=%0d rdata=%h expected=%h", tag, idx, cfg_rdata, exp);
      end
   endtask

   initial begin
      for (int k = 0; k < NGEN; k++) sh_gen[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < 8; i++) rd_check(i, 32'h0, "R1");
      decode(16'h002E, "R1");
      decode(16'h0378, "R1");
      decode(16'h0000, "R1");

      // R2: reserved bits dropped
      wr(0, 32'hFFFF_FFFF); rd_check(0, 32'h0000_3F04, "R2");
      wr(1, 32'hFFFF_FFFF); rd_check(1, 32'h0000_0003, "R2");
      wr(2, 32'hFFFF_FFFF); rd_check(2, 32'h00FC_FFFD, "R2");
      wr(6, 32'hFFFF_FFFF); rd_check(6, 32'h0, "R2");
      wr(7, 32'h1234_5678); rd_check(7, 32'h0, "R2");

      // working configuration
      wr(0, 32'h0000_3F04);
      wr(1, 32'h0);
      wr(2, 32'h0000_0681);     // 0x680..0x683
      wr(3, 32'h000C_1641);     // 0x1640..0x164F
      wr(4, 32'h0000_0000);     // disabled
      wr(5, 32'h00FC_0301);     // 0x300..0x3FF
      rd_check(3, 32'h000C_1641, "R2");

      // R3
      decode(16'h002E, "R3"); decode(16'h002F, "R3"); decode(16'h002D, "R3");
      decode(16'h004E, "R3"); decode(16'h004F, "R3"); decode(16'h0050, "R3");
      // R4
      decode(16'h0060, "R4"); decode(16'h0064, "R4"); decode(16'h0062, "R4");
      decode(16'h0066, "R4"); decode(16'h0061, "R4"); decode(16'h0063, "R4");
      decode(16'h0065, "R4");
      // R5
      decode(16'h0200, "R5"); decode(16'h0207, "R5"); decode(16'h0208, "R5");
      decode(16'h020F, "R5"); decode(16'h0210, "R5"); decode(16'h01FF, "R5");
      decode(16'h102E, "R5"); decode(16'hF208, "R5");
      // R6 select 00, with R11 overlap on generic window 3
      decode(16'h0378, "R11"); decode(16'h037F, "R6"); decode(16'h0778, "R6");
      decode(16'h077F, "R6"); decode(16'h0377, "R6"); decode(16'h0780, "R6");
      // R7 / R8
      decode(16'h0680, "R7"); decode(16'h0683, "R7"); decode(16'h0684, "R7");
      decode(16'h067F, "R7"); decode(16'h8680, "R7");
      decode(16'h1640, "R8"); decode(16'h164F, "R8"); decode(16'h1650, "R8");
      decode(16'h163F, "R8"); decode(16'h0300, "R8"); decode(16'h03A5, "R8");
      decode(16'h03FF, "R8"); decode(16'h0400, "R8");
      // R10: idle cycles and back-to-back strobes
      idle("R10"); decode(16'h0064, "R10"); idle("R10"); idle("R10");
      decode(16'h1644, "R10"); decode(16'h002F, "R10");

      // R6 select 10
      wr(1, 32'h2);
      decode(16'h03BC, "R6"); decode(16'h03BE, "R6"); decode(16'h03BF, "R6");
      decode(16'h07BC, "R6"); decode(16'h07BE, "R6"); decode(16'h07BF, "R6");
      decode(16'h0378, "R6"); decode(16'h0778, "R6");
      // R6 reserved selects
      wr(1, 32'h1);
      decode(16'h0378, "R6"); decode(16'h03BC, "R6"); decode(16'h0778, "R6");
      wr(1, 32'h3);
      decode(16'h07BD, "R6"); decode(16'h037A, "R6");

      // R3 individual enable removed
      wr(0, 32'h0000_2F04);
      decode(16'h002E, "R3"); decode(16'h004E, "R3");

      // R9: disabled and independent windows
      wr(5, 32'h00FC_0300);
      decode(16'h03A5, "R9"); decode(16'h0680, "R9"); decode(16'h1648, "R9");
      wr(4, 32'h0000_0000);
      decode(16'h0000, "R9");
      wr(4, 32'h0004_0801);     // 0x800..0x807 (bit 2 don't-care)
      decode(16'h0804, "R9"); decode(16'h0807, "R9"); decode(16'h0808, "R9");
      wr(2, 32'h0000_0000);
      decode(16'h0680, "R9");

      // R11: two generic windows overlapping
      wr(3, 32'h00FC_0801);
      decode(16'h0802, "R11"); decode(16'h08F0, "R11");

      idle("R10");
      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule